// File: doc/BRIEF.md
# Counter Overflow Interrupt Controller

This block collects single-cycle overflow pulses from sixteen general event counters and eight bandwidth counters. Each pulse sets a bit in a 24-bit sticky status vector. A matching 24-bit enable mask decides which pending bits reach the single level-sensitive interrupt line. Software reaches both vectors through a simple 32-bit register port with a synchronous write strobe and a read strobe.

The enable mask is never written directly. Separate set-on-one and clear-on-one locations change it, and a read-only location shows its current value. Pending status bits are acknowledged by writing ones to a separate status-clear location. Inside both vectors the general counters occupy the upper sixteen bits and the bandwidth counters the lower eight.

Top module: `ovf_irq_ctrl`

## Requirements
- R1: After a synchronous reset the enable mask and the status vector are all zero, and `irq` is low.
- R2: A write to offset 0xCB8 sets every enable bit whose `wdata` bit is one. The other enable bits keep their value.
- R3: A write to offset 0xCBC clears every enable bit whose `wdata` bit is one. The other enable bits keep their value.
- R4: A read of offset 0xCC0 returns the current enable mask in bits 23:0.
- R5: A pulse on `gen_ovf[k]` sets status bit 8+k, and a pulse on `bw_ovf[j]` sets status bit j, whatever the enable mask holds. Set bits stay set until they are cleared. A read of offset 0xCC8 returns the status vector in bits 23:0.
- R6: A write to offset 0xCC4 clears every status bit whose `wdata` bit is one. Writing 0xFFFFFF clears every pending bit.
- R7: `irq` is registered. One cycle after the status and enable registers change, it equals the OR over all bits of status AND enable.
- R8: When an overflow pulse and a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R9: Zero bits in a set, clear or status-clear write change nothing. Read bits 31:24 are always zero. A read of any other offset returns zero.
- R10: Read data appears on `rdata` on the clock edge that samples `rd_en`. It reflects the register state before any update made on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| gen_ovf | input | 16 | Overflow pulses from the general counters |
| bw_ovf | input | 8 | Overflow pulses from the bandwidth counters |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
Each of the 24 sources is walked one at a time through four steps: pulse the source, enable it, disable it, then acknowledge it. This separates a wrong bit position, a missing sticky latch and an enable that gates the latch instead of the line. Full-width writes of all ones and all zeros to every write location show that bits 31:24 are dropped and that zero bits have no effect. A collision test writes a status-clear covering two bits while one of them overflows in the same cycle, which separates set-over-clear priority from plain clearing. A read of an unmapped offset and a reset issued mid-run with state pending cover the remaining corners.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;
  localparam int unsigned REG_AW = 12;
  localparam logic [REG_AW-1:0] OFS_EN_SET = 12'hCB8;
  localparam logic [REG_AW-1:0] OFS_EN_CLR = 12'hCBC;
  localparam logic [REG_AW-1:0] OFS_EN_RD  = 12'hCC0;
  localparam logic [REG_AW-1:0] OFS_ST_CLR = 12'hCC4;
  localparam logic [REG_AW-1:0] OFS_ST_RD  = 12'hCC8;
endpackage

// File: rtl/ovf_mask_reg.sv
module ovf_mask_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (set_we)
      mask_q <= mask_q | wbits;
    else if (clr_we)
      mask_q <= mask_q & ~wbits;
  end
endmodule

// File: rtl/ovf_status_reg.sv
module ovf_status_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ovf,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] st_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // a new overflow outranks a simultaneous acknowledge
    always_ff @(posedge clk) begin
      if (rst)
        st_q[i] <= 1'b0;
      else if (ovf[i])
        st_q[i] <= 1'b1;
      else if (clr_we && wbits[i])
        st_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ovf_rd_port.sv
module ovf_rd_port
  import ovf_irq_pkg::*;
#(
  parameter int unsigned W      = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      mask,
  input  logic [W-1:0]      status,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    unique case (addr)
      OFS_EN_RD: sel[W-1:0] = mask;
      OFS_ST_RD: sel[W-1:0] = status;
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd_en)
      rdata_q <= sel;
  end
endmodule

// File: rtl/ovf_irq_ctrl.sv
module ovf_irq_ctrl
  import ovf_irq_pkg::*;
#(
  parameter int unsigned GEN_N  = 16,
  parameter int unsigned BW_N   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [GEN_N-1:0]  gen_ovf,
  input  logic [BW_N-1:0]   bw_ovf,
  output logic              irq
);
  localparam int unsigned SRC_N = GEN_N + BW_N;

  logic [SRC_N-1:0] ovf_vec;
  logic [SRC_N-1:0] wbits;
  logic [SRC_N-1:0] en_q;
  logic [SRC_N-1:0] st_q;
  logic             unused_hi;
  logic             irq_q;

  // general counters sit above the bandwidth counters
  assign ovf_vec   = {gen_ovf, bw_ovf};
  assign wbits     = wdata[SRC_N-1:0];
  assign unused_hi = ^wdata[DATA_W-1:SRC_N];

  ovf_mask_reg #(.W(SRC_N)) mask_i (
    .clk    (clk),
    .rst    (rst),
    .set_we (wr_en && (addr == OFS_EN_SET)),
    .clr_we (wr_en && (addr == OFS_EN_CLR)),
    .wbits  (wbits),
    .mask_q (en_q)
  );

  ovf_status_reg #(.W(SRC_N)) stat_i (
    .clk    (clk),
    .rst    (rst),
    .ovf    (ovf_vec),
    .clr_we (wr_en && (addr == OFS_ST_CLR)),
    .wbits  (wbits),
    .st_q   (st_q)
  );

  ovf_rd_port #(.W(SRC_N), .DATA_W(DATA_W)) rd_i (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .mask    (en_q),
    .status  (st_q),
    .rdata_q (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)
      irq_q <= 1'b0;
    else
      irq_q <= |(st_q & en_q);
  end

  assign irq = irq_q;
endmodule

// File: rtl/ovf_irq_chk.sv
module ovf_irq_chk
  import ovf_irq_pkg::*;
#(
  parameter int unsigned SRC_N = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [REG_AW-1:0] addr,
  input logic [SRC_N-1:0]  wbits,
  input logic [SRC_N-1:0]  ovf_vec,
  input logic [SRC_N-1:0]  en_q,
  input logic [SRC_N-1:0]  st_q,
  input logic              irq
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (en_q == '0 && st_q == '0 && !irq));

  p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_EN_SET) |=> ((en_q & $past(wbits)) == $past(wbits)));

  p_en_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_EN_CLR) |=> ((en_q & $past(wbits)) == '0));

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (|ovf_vec) |=> ((st_q & $past(ovf_vec)) == $past(ovf_vec)));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_ST_CLR && |(ovf_vec & wbits))
      |=> ((st_q & $past(ovf_vec & wbits)) == $past(ovf_vec & wbits)));

  p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (irq == |($past(st_q & en_q))));

  p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> $stable(en_q));

  p_status_noclr_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> ((st_q & $past(st_q)) == $past(st_q)));
endmodule

bind ovf_irq_ctrl ovf_irq_chk #(.SRC_N(SRC_N)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wbits   (wbits),
  .ovf_vec (ovf_vec),
  .en_q    (en_q),
  .st_q    (st_q),
  .irq     (irq)
);

// File: tb/ovf_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module ovf_irq_ctrl_tb_top;
  localparam logic [11:0] A_SET  = 12'hCB8;
  localparam logic [11:0] A_CLR  = 12'hCBC;
  localparam logic [11:0] A_EN   = 12'hCC0;
  localparam logic [11:0] A_SCLR = 12'hCC4;
  localparam logic [11:0] A_ST   = 12'hCC8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] gen_ovf = '0;
  logic [7:0]  bw_ovf = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [23:0] en_m = '0;
  logic [23:0] st_m = '0;

  always #2.5 clk = ~clk;

  ovf_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gen_ovf(gen_ovf), .bw_ovf(bw_ovf), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    if (a == A_SET)  en_m = en_m | d[23:0];
    if (a == A_CLR)  en_m = en_m & ~d[23:0];
    if (a == A_SCLR) st_m = st_m & ~d[23:0];
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [23:0] src_bit(input int i);
    logic [23:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  task automatic pulse(input int i);
    @(negedge clk);
    if (i >= 8) gen_ovf[i-8] = 1'b1;
    else        bw_ovf[i] = 1'b1;
    @(negedge clk);
    gen_ovf = '0; bw_ovf = '0;
    st_m = st_m | src_bit(i);
  endtask

  task automatic chk_irq(input string tag);
    @(negedge clk);
    check(tag, {31'd0, irq}, {31'd0, |(st_m & en_m)});
  endtask

  task automatic chk_regs(input string tag);
    logic [31:0] d;
    rd(A_EN, d);
    check({tag, " enable"}, d, {8'd0, en_m});
    rd(A_ST, d);
    check({tag, " status"}, d, {8'd0, st_m});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-reqs actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk_regs("R1 reset");

    // R5 R2 R3 R6 R7: walk each source
    for (int i = 0; i < 24; i++) begin
      pulse(i);
      chk_irq("R5 latched while disabled keeps irq low");
      rd(A_ST, d);
      check("R5 status position", d, {8'd0, src_bit(i)});
      wr(A_SET, {8'd0, src_bit(i)});
      chk_irq("R2 R7 enable raises irq");
      rd(A_EN, d);
      check("R4 enable readback", d, {8'd0, src_bit(i)});
      wr(A_CLR, {8'd0, src_bit(i)});
      chk_irq("R3 R7 disable drops irq");
      wr(A_SET, {8'd0, src_bit(i)});
      wr(A_SCLR, {8'd0, src_bit(i)});
      chk_irq("R6 R7 ack drops irq");
      rd(A_ST, d);
      check("R6 status cleared", d, 32'd0);
      wr(A_CLR, {8'd0, src_bit(i)});
    end

    // R9 upper bits dropped, zero writes no effect
    wr(A_SET, 32'hFFFF_FFFF);
    rd(A_EN, d);
    check("R9 upper enable bits read zero", d, 32'h00FF_FFFF);
    wr(A_CLR, 32'h00A5_5A0F);
    chk_regs("R3 partial clear");
    pulse(3); pulse(12); pulse(23);
    wr(A_SET, 32'd0);
    wr(A_CLR, 32'd0);
    wr(A_SCLR, 32'd0);
    chk_regs("R9 zero writes");
    chk_irq("R7 multiple pending");
    rd(12'hC00, d);
    check("R9 unmapped offset", d, 32'd0);

    // R6 clear all
    for (int i = 0; i < 24; i += 5) pulse(i);
    wr(A_SCLR, 32'h00FF_FFFF);
    chk_regs("R6 clear all");
    chk_irq("R6 irq after clear all");

    // R8 collision: clear bits 9 and 2 while bit 9 overflows
    pulse(9); pulse(2);
    @(negedge clk);
    wr_en = 1'b1; addr = A_SCLR; wdata = 32'h0000_0204; gen_ovf[1] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; gen_ovf = '0;
    st_m = 24'h000200;
    rd(A_ST, d);
    check("R8 set beats clear", d, {8'd0, st_m});

    // R10 read captures pre-update state
    @(negedge clk);
    rd_en = 1'b1; addr = A_ST; bw_ovf[6] = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; bw_ovf = '0;
    check("R10 read before same-edge update", rdata, 32'h0000_0200);
    st_m = st_m | src_bit(6);
    chk_regs("R10 after update");

    // R1 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    en_m = '0; st_m = '0;
    check("R1 irq after mid reset", {31'd0, irq}, 32'd0);
    chk_regs("R1 mid reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule